// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block times the bus cycles of a processor whose address and data share one 16-bit path. A client places a request on a simple valid/accept interface. The request can be a memory read, a memory write, an I/O read, an I/O write or an interrupt acknowledge. The sequencer then runs the fixed state order T1, T2, T3, zero or more wait states TW, and T4. It places the address on the shared path in T1 and pulses the address latch strobe so that external latches can capture it. From T2 onward the shared path carries data. The block drives the read, write and acknowledge strobes, the transceiver enable and direction, the memory/I-O select, the byte-high enable and the four upper address lines.

The shared bus is split into an output value, an output enable and an input value, so the pads can sit outside the block. A second enable covers the strobes and the upper address lines. The sequencer releases both when another master is granted the bus. Read data is captured on the edge that leaves the last T3 or TW. It is presented with a one-cycle valid pulse during T4.

Top module: `bus_cycle_seq`

## Requirements
- R1: A cycle always steps T1, T2, T3, any TW states, then T4. With no request waiting, the sequencer then returns to idle. The address latch strobe `ale` is high in T1 only. In idle, every active-low strobe is high.
- R2: In T1 the shared bus carries address bits 15:0. During T2 to T4 of a write it carries the write data. For a read or acknowledge cycle, `ad_in` is captured on the edge that ends the final T3/TW and appears on `rdata` with `rdata_valid` high during T4.
- R3: `ready` is sampled on the edge that ends T3 and on the edge that ends each TW. When it is low, a TW state follows. When it is high, T4 follows.
- R4: For a read (`req_kind` 0 = memory read, 2 = I/O read), `rd_n` and `den_n` are low in T2, T3 and every TW and high in T4. `dt_r` is 0 (receive) from T1 to T4.
- R5: For a write (`req_kind` 1 = memory write, 3 = I/O write), `wr_n` and `den_n` are low from T2 through T4. `dt_r` is 1 (transmit). `ad_oe` is high from T1 through T4.
- R6: For an interrupt acknowledge (`req_kind` 4), `inta_n` is low in T2, T3 and every TW. `ad_oe` stays low for the whole cycle. `ale` still pulses in T1. `rd_n` and `wr_n` stay high.
- R7: `m_io` is 1 during memory cycles and `a_hi` carries address bits 19:16. During I/O and acknowledge cycles, `m_io` is 0 and `a_hi` is 0.
- R8: When `req_hi` is set, `bhe_n` is low from T1 to T4 of that cycle. Otherwise it stays high.
- R9: A `hold` seen in T1 to T3 lets the current cycle finish. After T4, or straight from idle, the block enters the grant state: `hlda` is 1 and both `bus_oe` and `ad_oe` are 0. One clock after `hold` is sampled low, the block is back in idle with `bus_oe` at 1. In idle, `hold` takes priority over a pending request.
- R10: Reset is synchronous and active high. A reset taken in the middle of a cycle returns the block to idle with all strobes inactive, `rdata` at 0 and `rdata_valid` at 0.
- R11: A request accepted in T4 starts T1 on the next clock, with no idle state in between.
- R12: `req_ack` is high only in idle or T4 while `req_valid` is high and `hold` is low. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending |
| req_kind | input | 3 | 0 mem read, 1 mem write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_hi | input | 1 | Transfer uses the upper byte lane |
| req_ack | output | 1 | Request accepted on this edge |
| ready | input | 1 | Target ready; low inserts wait states |
| hold | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus granted to the other master |
| ad_in | input | 16 | Value read from the shared bus |
| ad_out | output | 16 | Value driven onto the shared bus |
| ad_oe | output | 1 | Shared bus output enable |
| a_hi | output | 4 | Address bits 19:16 |
| bus_oe | output | 1 | Enable for strobes and `a_hi` |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Direction, 1 transmit / 0 receive |
| m_io | output | 1 | 1 memory, 0 I/O |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | High in T4 of a read or acknowledge |

## Verification
The embedded properties assume that `req_kind` only takes the five listed codes while `req_valid` is high. They assume that `ready`, `hold` and `req_valid` are settled at each rising edge. They also assume that reset lasts long enough to reach idle. The directed stimulus changes every input on the falling edge and issues only codes 0 to 4. It raises `hold` only at points where the state it targets is known, and it holds reset for four clocks. Under these conditions the wait-state, strobe-exclusivity and bus-release properties are exercised over complete cycles.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int KIND_W = 3;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5,
        S_HOLD = 3'd6
    } bseq_state_e;

    typedef enum logic [KIND_W-1:0] {
        K_MRD  = 3'd0,
        K_MWR  = 3'd1,
        K_IORD = 3'd2,
        K_IOWR = 3'd3,
        K_INTA = 3'd4
    } bseq_kind_e;

    typedef struct packed {
        bseq_kind_e          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                hi;
    } bseq_req_t;

    function automatic bseq_kind_e to_kind(input logic [KIND_W-1:0] code);
        case (code)
            3'd1:    return K_MWR;
            3'd2:    return K_IORD;
            3'd3:    return K_IOWR;
            3'd4:    return K_INTA;
            default: return K_MRD;
        endcase
    endfunction

    function automatic logic kind_writes(input bseq_kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_reads(input bseq_kind_e k);
        return (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_not_mem(input bseq_kind_e k);
        return (k == K_IORD) || (k == K_IOWR) || (k == K_INTA);
    endfunction

    function automatic logic in_cycle(input bseq_state_e s);
        return (s == S_T1) || (s == S_T2) || (s == S_T3) || (s == S_TW) || (s == S_T4);
    endfunction

    function automatic logic in_data(input bseq_state_e s);
        return (s == S_T2) || (s == S_T3) || (s == S_TW);
    endfunction
endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [KIND_W-1:0]   req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_hi,
    input  logic                ready,
    input  logic                hold,
    output bseq_state_e         state,
    output bseq_req_t           cur,
    output logic                accept
);
    bseq_state_e nxt;

    assign accept = req_valid && !hold && ((state == S_IDLE) || (state == S_T4));

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  nxt = hold ? S_HOLD : (accept ? S_T1 : S_IDLE);
            S_T1:    nxt = S_T2;
            S_T2:    nxt = S_T3;
            S_T3:    nxt = ready ? S_T4 : S_TW;
            S_TW:    nxt = ready ? S_T4 : S_TW;
            S_T4:    nxt = hold ? S_HOLD : (accept ? S_T1 : S_IDLE);
            S_HOLD:  nxt = hold ? S_HOLD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                cur.kind  <= to_kind(req_kind);
                cur.addr  <= req_addr;
                cur.wdata <= req_wdata;
                cur.hi    <= req_hi;
            end
        end
    end

    p_t1_next_r1: assert property (@(posedge clk) disable iff (rst)
        state == S_T1 |=> state == S_T2);
    p_t2_next_r1: assert property (@(posedge clk) disable iff (rst)
        state == S_T2 |=> state == S_T3);
    p_wait_stay_r3: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_T3, S_TW}) && !ready |=> state == S_TW);
    p_wait_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_T3, S_TW}) && ready |=> state == S_T4);
    p_hold_after_t4_r9: assert property (@(posedge clk) disable iff (rst)
        state == S_T4 && hold |=> state == S_HOLD);
    p_chain_r11: assert property (@(posedge clk) disable iff (rst)
        state == S_T4 && accept |=> state == S_T1);
    p_accept_gate_r12: assert property (@(posedge clk) disable iff (rst)
        accept |-> !hold && (state inside {S_IDLE, S_T4}));
endmodule

// File: rtl/bseq_strobes.sv
module bseq_strobes
    import bseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bseq_state_e   state,
    input  bseq_kind_e    kind,
    input  logic          hi,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          inta_n,
    output logic          den_n,
    output logic          dt_r,
    output logic          m_io,
    output logic          bhe_n,
    output logic          bus_oe,
    output logic          hlda
);
    logic active;
    logic data_ph;
    logic wr_k;

    assign active  = in_cycle(state);
    assign data_ph = in_data(state);
    assign wr_k    = kind_writes(kind);

    always_comb begin
        ale    = (state == S_T1);
        rd_n   = !(data_ph && kind_reads(kind));
        inta_n = !(data_ph && (kind == K_INTA));
        wr_n   = !(wr_k && (data_ph || (state == S_T4)));
        den_n  = !(active && (wr_k ? (state != S_T1) : data_ph));
        dt_r   = active ? wr_k : 1'b1;
        m_io   = active ? !kind_not_mem(kind) : 1'b1;
        bhe_n  = !(active && hi);
        bus_oe = (state != S_HOLD);
        hlda   = (state == S_HOLD);
    end

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);
    p_ale_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ale |-> rd_n && wr_n && inta_n);
    p_ale_single_r1: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    p_rd_release_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_n && state == S_TW |-> !den_n);
endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
    import bseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bseq_state_e         state,
    input  bseq_req_t           cur,
    input  logic                ready,
    input  logic [DATA_W-1:0]   ad_in,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [HI_W-1:0]     a_hi,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_valid
);
    logic wr_k;
    logic late;
    logic capture;

    assign wr_k    = kind_writes(cur.kind);
    assign late    = in_data(state) || (state == S_T4);
    assign capture = (state == S_T3 || state == S_TW) && ready && !wr_k;

    always_comb begin
        ad_oe  = (cur.kind != K_INTA) && ((state == S_T1) || (wr_k && late));
        ad_out = '0;
        if (state == S_T1)
            ad_out = cur.addr[DATA_W-1:0];
        else if (wr_k && late)
            ad_out = cur.wdata;
        a_hi = (in_cycle(state) && !kind_not_mem(cur.kind)) ? cur.addr[ADDR_W-1:DATA_W] : '0;
        rdata_valid = (state == S_T4) && !wr_k;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= ad_in;
    end

    p_inta_float_r6: assert property (@(posedge clk) disable iff (rst)
        in_cycle(state) && cur.kind == K_INTA |-> !ad_oe);
    p_io_ahi_r7: assert property (@(posedge clk) disable iff (rst)
        in_cycle(state) && kind_not_mem(cur.kind) |-> a_hi == '0);
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        state == S_T4 |=> $stable(rdata));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [KIND_W-1:0]   req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_hi,
    output logic                req_ack,
    input  logic                ready,
    input  logic                hold,
    output logic                hlda,
    input  logic [DATA_W-1:0]   ad_in,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [HI_W-1:0]     a_hi,
    output logic                bus_oe,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                inta_n,
    output logic                den_n,
    output logic                dt_r,
    output logic                m_io,
    output logic                bhe_n,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_valid
);
    bseq_state_e state;
    bseq_req_t   cur;

    bseq_fsm u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_hi(req_hi),
        .ready(ready), .hold(hold),
        .state(state), .cur(cur), .accept(req_ack)
    );

    bseq_strobes u_strobes (
        .clk(clk), .rst(rst), .state(state), .kind(cur.kind), .hi(cur.hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
        .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n), .bus_oe(bus_oe), .hlda(hlda)
    );

    bseq_addr u_addr (
        .clk(clk), .rst(rst), .state(state), .cur(cur), .ready(ready),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    p_hold_float_r9: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !ad_oe && !bus_oe && rd_n && wr_n && inta_n);
    p_hold_return_r9: assert property (@(posedge clk) disable iff (rst)
        hlda && !hold |=> bus_oe && !hlda);
    p_no_ack_grant_r12: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !req_ack);
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> ale == 1'b0 && rd_n && wr_n && inta_n && den_n && !rdata_valid);
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_hi = 1'b0;
    logic        req_ack;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  a_hi;
    logic        bus_oe, ale, rd_n, wr_n, inta_n, den_n, dt_r, m_io, bhe_n;
    logic [15:0] rdata;
    logic        rdata_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hi(req_hi),
        .req_ack(req_ack), .ready(ready), .hold(hold), .hlda(hlda),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
        .bus_oe(bus_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
        .den_n(den_n), .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 ale idle"}, ale, 0);
        chk({tag, " R1 strobes idle"}, {rd_n, wr_n, inta_n, den_n, bhe_n}, 5'h1f);
        chk({tag, " R1 ad_oe idle"}, ad_oe, 0);
        chk({tag, " R9 hlda idle"}, hlda, 0);
    endtask

    // one complete cycle of the given kind with nwait wait states
    task automatic do_cycle(input int k, input logic [19:0] addr, input logic [15:0] wd,
                            input logic hi, input logic [15:0] rv, input int nwait);
        logic is_wr = (k == 1) || (k == 3);
        logic is_ia = (k == 4);
        logic is_rd = (k == 0) || (k == 2);
        logic is_mem = (k == 0) || (k == 1);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_addr = addr; req_wdata = wd; req_hi = hi;
        #1 chk("R12 ack in idle", req_ack, 1);
        @(negedge clk);                               // T1
        req_valid = 1'b0;
        chk("R1 ale T1", ale, 1);
        chk("R6 R5 ad_oe T1", ad_oe, !is_ia);
        if (!is_ia) chk("R2 address T1", ad_out, addr[15:0]);
        chk("R7 m_io", m_io, is_mem);
        chk("R7 a_hi", a_hi, is_mem ? addr[19:16] : 4'h0);
        chk("R8 bhe_n T1", bhe_n, !hi);
        chk("R4 R5 dt_r T1", dt_r, is_wr);
        chk("R1 strobes off T1", {rd_n, wr_n, inta_n, den_n}, 4'hf);
        ready = (nwait == 0);
        ad_in = rv;
        for (int ph = 0; ph < 2 + nwait; ph++) begin   // T2, T3, TW...
            @(negedge clk);
            if (ph >= 2) ready = (ph - 1 == nwait);
            chk("R1 ale data", ale, 0);
            chk("R4 rd_n data", rd_n, !is_rd);
            chk("R5 wr_n data", wr_n, !is_wr);
            chk("R6 inta_n data", inta_n, !is_ia);
            chk("R4 R5 den_n data", den_n, 0);
            chk("R5 ad_oe data", ad_oe, is_wr);
            if (is_wr) chk("R2 wdata data", ad_out, wd);
            chk("R3 no T4 yet", rdata_valid, 0);
            chk("R8 bhe_n data", bhe_n, !hi);
        end
        @(negedge clk);                               // T4
        ready = 1'b1;
        chk("R4 rd_n T4", rd_n, 1);
        chk("R6 inta_n T4", inta_n, 1);
        chk("R5 wr_n T4", wr_n, !is_wr);
        chk("R5 den_n T4", den_n, !is_wr);
        chk("R3 R2 rdata_valid T4", rdata_valid, !is_wr);
        if (!is_wr) chk("R2 rdata T4", rdata, rv);
        if (is_wr) chk("R2 wdata T4", ad_out, wd);
        chk("R7 m_io T4", m_io, is_mem);
        @(negedge clk);
        chk_idle("after cycle");
    endtask

    task automatic t_reset;
        chk_idle("R10 reset");
        chk("R10 rdata reset", rdata, 0);
        chk("R10 bus_oe reset", bus_oe, 1);
    endtask

    task automatic t_hold_mid;
        @(negedge clk);
        req_valid = 1; req_kind = 3'd1; req_addr = 20'h1_2345; req_wdata = 16'hBEEF; req_hi = 0;
        @(negedge clk);                               // T1
        req_valid = 0;
        @(negedge clk);                               // T2
        hold = 1;
        @(negedge clk);                               // T3
        chk("R9 cycle continues T3", hlda, 0);
        @(negedge clk);                               // T4
        chk("R9 cycle completes T4", wr_n, 0);
        chk("R9 no grant in T4", hlda, 0);
        req_valid = 1; req_kind = 3'd0; req_addr = 20'h0_0042;
        #1 chk("R12 no ack under hold", req_ack, 0);
        @(negedge clk);
        chk("R9 granted", hlda, 1);
        chk("R9 bus released", {bus_oe, ad_oe}, 2'b00);
        @(negedge clk);
        chk("R12 no ack in grant", req_ack, 0);
        hold = 0;
        @(negedge clk);
        chk("R9 drive again one clock later", bus_oe, 1);
        chk("R9 hlda dropped", hlda, 0);
        #1 chk("R12 ack after grant", req_ack, 1);
        @(negedge clk);
        chk("R9 pending starts", ale, 1);
        req_valid = 0;
        repeat (4) @(negedge clk);
        chk_idle("R9 after pending");
    endtask

    task automatic t_hold_idle;
        @(negedge clk);
        hold = 1; req_valid = 1; req_kind = 3'd0; req_addr = 20'h0_0010;
        #1 chk("R9 hold wins ack", req_ack, 0);
        @(negedge clk);
        chk("R9 hold wins grant", hlda, 1);
        chk("R9 no ale in grant", ale, 0);
        hold = 0; req_valid = 0;
        @(negedge clk);
        chk_idle("R9 idle after grant");
    endtask

    task automatic t_chain;
        @(negedge clk);
        req_valid = 1; req_kind = 3'd0; req_addr = 20'h4_1111; req_hi = 0;
        @(negedge clk);                               // T1
        req_addr = 20'h5_2222;
        chk("R12 no ack in T1", req_ack, 0);
        @(negedge clk);                               // T2
        @(negedge clk);                               // T3
        @(negedge clk);                               // T4
        #1 chk("R11 ack in T4", req_ack, 1);
        @(negedge clk);
        chk("R11 T1 follows T4", ale, 1);
        chk("R11 second address", ad_out, 16'h2222);
        chk("R11 second a_hi", a_hi, 4'h5);
        req_valid = 0;
        repeat (4) @(negedge clk);
        chk_idle("R11 after chain");
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        req_valid = 1; req_kind = 3'd2; req_addr = 20'h0_0300;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);                               // T2
        chk("R10 rd active before reset", rd_n, 0);
        rst = 1;
        @(negedge clk);
        chk("R10 rd released by reset", rd_n, 1);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        chk("R10 rdata_valid reset", rdata_valid, 0);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        do_cycle(0, 20'hA_5432, 16'h0000, 1'b1, 16'h7E81, 0);
        do_cycle(3, 20'h3_00F0, 16'hC3A5, 1'b0, 16'h0000, 2);
        do_cycle(1, 20'h9_8766, 16'h1357, 1'b0, 16'h0000, 1);
        do_cycle(2, 20'hF_0044, 16'h0000, 1'b1, 16'hAA55, 0);
        do_cycle(4, 20'h0_0000, 16'h0000, 1'b0, 16'h0021, 1);
        do_cycle(0, 20'h7_0002, 16'h0000, 1'b0, 16'h1234, 3);
        t_hold_mid();
        t_hold_idle();
        t_chain();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule